// File: doc/BRIEF.md
# Serial Channel Register Front End

This block is the register front end of one channel in a dual-channel asynchronous serial controller. It decodes byte-wide bus reads and writes that fall in its own eight-register window. It keeps the channel's three mode registers behind a single address and steers accesses to them with an internal pointer. It interprets command writes that switch the receiver and transmitter on and off, flush either side, clear sticky status and start or stop a line break. It assembles a status byte from live flags and sticky error flags, and passes holding-register traffic to the transmit and receive data paths.

The shifters, FIFOs and baud generator sit outside this block. The block gives them the enables, one-cycle flush strobes, the break request, the frame format and the FIFO and baud-table settings. It takes back their ready and empty flags, their error events and the received byte.

Top module: `sio_chan_regs`

## Requirements
- R1: A bus access is taken only when `bus_cs` is high and `bus_addr[ADDR_W-1:3]` equals `CHAN_IDX`. Any other access changes no state and drives no strobe, and `bus_rdata` reads 0 for it.
- R2: After reset the receiver and transmitter are disabled, the break request is low, all mode fields and `clk_select` are 0, all sticky flags are clear, and the mode pointer selects MR1.
- R3: Offset 0 is the mode address, and each read or write there advances the pointer MR0 to MR1 to MR2. Once it reaches MR2 it stays there. Command code 0x1 moves the pointer to MR1 and code 0xB moves it to MR0. A read at offset 0 returns the register the pointer selects.
- R4: `fmt_data_bits` is MR1[1:0], where 0 to 3 mean 5 to 8 data bits. `fmt_parity` is MR1[4:2], where 0 is even, 1 is odd and 4 is none.
- R5: `fmt_stop_len` is MR2[3:0], where 0x7 is one stop bit and 0xF is two.
- R6: `baud_table` is MR0[2:0], where 0 is normal, 1 is extended-1 and 5 is extended-2. `fifo_deep` is MR0[3] and `tx_lvl_half` is MR0[4].
- R7: A write at offset 2 is a command. Bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. If the enable and disable bits for one side are both set, the disable takes effect. These bits act in the same write as the command code in bits 7:4.
- R8: Code 0x2 makes `rx_flush` high for exactly the cycle after the write. Code 0x3 does the same for `tx_flush`.
- R9: Code 0x6 raises `brk_active` and code 0x7 lowers it. Other codes leave it unchanged.
- R10: A read at offset 1 returns the status byte. Bit 0 is `rx_ready_in`, bit 1 is `rx_full_in`, bit 2 is `tx_ready_in`, bit 3 is `tx_empty_in`. Bits 4 to 7 are sticky flags set by `ovr_evt`, `par_evt`, `frm_evt` and `brk_evt`.
- R11: Code 0x4 clears the overrun, parity and framing flags and leaves the break flag. Code 0x5 clears only the break flag. An event in the same cycle as its clear leaves the flag set.
- R12: A write at offset 3 makes `tx_push` high for the next cycle, with `tx_byte` holding the written value. A read at offset 3 returns `rx_byte` and makes `rx_pop` high for the next cycle.
- R13: A write at offset 1 loads `clk_select` with the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus select |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |
| rx_flush | output | 1 | Receiver reset strobe |
| tx_flush | output | 1 | Transmitter reset strobe |
| brk_active | output | 1 | Send line break |
| fmt_data_bits | output | 2 | Data-bit code |
| fmt_parity | output | 3 | Parity code |
| fmt_stop_len | output | 4 | Stop-length code |
| fifo_deep | output | 1 | Deep FIFO enable |
| tx_lvl_half | output | 1 | Transmit-ready at half full |
| baud_table | output | 3 | Baud table select |
| clk_select | output | 8 | Clock select byte |
| tx_push | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_pop | output | 1 | Receive byte taken strobe |
| rx_byte | input | 8 | Received byte |
| rx_ready_in | input | 1 | Receive data available |
| rx_full_in | input | 1 | Receive FIFO full |
| tx_ready_in | input | 1 | Transmit FIFO has room |
| tx_empty_in | input | 1 | Transmitter idle |
| ovr_evt | input | 1 | Overrun event |
| par_evt | input | 1 | Parity error event |
| frm_evt | input | 1 | Framing error event |
| brk_evt | input | 1 | Break received event |

## Verification
The pointer is exercised in three ways. A write sequence starts from the reset position, a sequence is re-aimed with code 0x1, and a read-back sequence starts from code 0xB. Together they show whether MR1 and MR2 are updated in the right order, whether the pointer sticks at MR2, and whether reads advance the pointer as writes do. Commands are sent with enable and disable bits alone, with both bits set for one side, and combined with a code in the same byte. These cases separate the priority of disable over enable from the decoding of the code field. The status flags are cleared both apart from their events and in the same cycle as an event, which tells the set priority apart from the scope of each clear. Accesses outside the window are aimed at registers whose values are already known.

// File: rtl/sio_chan_pkg.sv
package sio_chan_pkg;
  localparam int WIN_W = 3;

  localparam logic [WIN_W-1:0] OFS_MODE = 3'd0;
  localparam logic [WIN_W-1:0] OFS_STAT = 3'd1;
  localparam logic [WIN_W-1:0] OFS_CMD  = 3'd2;
  localparam logic [WIN_W-1:0] OFS_HOLD = 3'd3;

  typedef enum logic [1:0] {
    PTR_MR0 = 2'd0,
    PTR_MR1 = 2'd1,
    PTR_MR2 = 2'd2
  } mode_ptr_e;

  localparam logic [3:0] CODE_PTR_MR1 = 4'h1;
  localparam logic [3:0] CODE_RX_RST  = 4'h2;
  localparam logic [3:0] CODE_TX_RST  = 4'h3;
  localparam logic [3:0] CODE_ERR_CLR = 4'h4;
  localparam logic [3:0] CODE_BRK_CLR = 4'h5;
  localparam logic [3:0] CODE_BRK_ON  = 4'h6;
  localparam logic [3:0] CODE_BRK_OFF = 4'h7;
  localparam logic [3:0] CODE_PTR_MR0 = 4'hB;

  typedef struct packed {
    logic mode_wr;
    logic mode_rd;
    logic stat_rd;
    logic csel_wr;
    logic cmd_wr;
    logic hold_wr;
    logic hold_rd;
  } acc_t;
endpackage

// File: rtl/sio_chan_dec.sv
module sio_chan_dec
  import sio_chan_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CHAN_IDX = 0
) (
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_t              acc
);
  localparam int TAG_W = ADDR_W - WIN_W;
  localparam logic [TAG_W-1:0] TAG = TAG_W'(CHAN_IDX);

  logic             hit;
  logic             wr;
  logic             rd;
  logic [WIN_W-1:0] ofs;

  always_comb begin
    hit = bus_cs && (bus_addr[ADDR_W-1:WIN_W] == TAG);
    wr  = hit && bus_we;
    rd  = hit && bus_re && !bus_we;
    ofs = bus_addr[WIN_W-1:0];
    acc         = '0;
    acc.mode_wr = wr && (ofs == OFS_MODE);
    acc.mode_rd = rd && (ofs == OFS_MODE);
    acc.stat_rd = rd && (ofs == OFS_STAT);
    acc.csel_wr = wr && (ofs == OFS_STAT);
    acc.cmd_wr  = wr && (ofs == OFS_CMD);
    acc.hold_wr = wr && (ofs == OFS_HOLD);
    acc.hold_rd = rd && (ofs == OFS_HOLD);
  end
endmodule

// File: rtl/sio_chan_mode.sv
module sio_chan_mode
  import sio_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic       mode_rd,
  input  logic [7:0] wdata,
  input  logic       aim_mr0,
  input  logic       aim_mr1,
  output logic [7:0] rd_val,
  output logic [1:0] fmt_data_bits,
  output logic [2:0] fmt_parity,
  output logic [3:0] fmt_stop_len,
  output logic       fifo_deep,
  output logic       tx_lvl_half,
  output logic [2:0] baud_table
);
  mode_ptr_e  ptr_q, ptr_d;
  logic [7:0] mr0_q, mr0_d;
  logic [7:0] mr1_q, mr1_d;
  logic [7:0] mr2_q, mr2_d;
  logic       upd_en;

  always_comb begin
    ptr_d  = ptr_q;
    mr0_d  = mr0_q;
    mr1_d  = mr1_q;
    mr2_d  = mr2_q;
    upd_en = aim_mr0 || aim_mr1 || mode_wr || mode_rd;
    if (aim_mr0) begin
      ptr_d = PTR_MR0;
    end else if (aim_mr1) begin
      ptr_d = PTR_MR1;
    end else if (mode_wr || mode_rd) begin
      if (mode_wr) begin
        case (ptr_q)
          PTR_MR0: mr0_d = wdata;
          PTR_MR1: mr1_d = wdata;
          default: mr2_d = wdata;
        endcase
      end
      ptr_d = (ptr_q == PTR_MR0) ? PTR_MR1 : PTR_MR2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_MR1;
      mr0_q <= '0;
      mr1_q <= '0;
      mr2_q <= '0;
    end else if (upd_en) begin
      ptr_q <= ptr_d;
      mr0_q <= mr0_d;
      mr1_q <= mr1_d;
      mr2_q <= mr2_d;
    end
  end

  always_comb begin
    case (ptr_q)
      PTR_MR0: rd_val = mr0_q;
      PTR_MR1: rd_val = mr1_q;
      default: rd_val = mr2_q;
    endcase
  end

  assign baud_table    = mr0_q[2:0];
  assign fifo_deep     = mr0_q[3];
  assign tx_lvl_half   = mr0_q[4];
  assign fmt_data_bits = mr1_q[1:0];
  assign fmt_parity    = mr1_q[4:2];
  assign fmt_stop_len  = mr2_q[3:0];

  assert_ptr_stays_mr2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_wr || mode_rd) && !aim_mr0 && !aim_mr1 && ptr_q == PTR_MR2) |=> (ptr_q == PTR_MR2));

  assert_mr1_then_mr2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !aim_mr0 && !aim_mr1 && ptr_q == PTR_MR1) |=> (ptr_q == PTR_MR2 && mr1_q == $past(wdata)));
endmodule

// File: rtl/sio_chan_cmd.sv
module sio_chan_cmd
  import sio_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] wdata,
  output logic       rx_enable,
  output logic       tx_enable,
  output logic       rx_flush,
  output logic       tx_flush,
  output logic       brk_active,
  output logic       err_clr,
  output logic       brk_clr,
  output logic       aim_mr0,
  output logic       aim_mr1
);
  logic [3:0] code;
  logic rx_en_q, rx_en_d, tx_en_q, tx_en_d, brk_q, brk_d;
  logic rx_fl_q, rx_fl_d, tx_fl_q, tx_fl_d;

  always_comb begin
    code    = wdata[7:4];
    rx_en_d = rx_en_q;
    tx_en_d = tx_en_q;
    brk_d   = brk_q;
    if (wdata[0]) rx_en_d = 1'b1;
    if (wdata[1]) rx_en_d = 1'b0;
    if (wdata[2]) tx_en_d = 1'b1;
    if (wdata[3]) tx_en_d = 1'b0;
    if (code == CODE_BRK_ON)  brk_d = 1'b1;
    if (code == CODE_BRK_OFF) brk_d = 1'b0;
    rx_fl_d = cmd_wr && (code == CODE_RX_RST);
    tx_fl_d = cmd_wr && (code == CODE_TX_RST);
    err_clr = cmd_wr && (code == CODE_ERR_CLR);
    brk_clr = cmd_wr && (code == CODE_BRK_CLR);
    aim_mr0 = cmd_wr && (code == CODE_PTR_MR0);
    aim_mr1 = cmd_wr && (code == CODE_PTR_MR1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      brk_q   <= 1'b0;
    end else if (cmd_wr) begin
      rx_en_q <= rx_en_d;
      tx_en_q <= tx_en_d;
      brk_q   <= brk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_fl_q <= 1'b0;
      tx_fl_q <= 1'b0;
    end else begin
      rx_fl_q <= rx_fl_d;
      tx_fl_q <= tx_fl_d;
    end
  end

  assign rx_enable  = rx_en_q;
  assign tx_enable  = tx_en_q;
  assign brk_active = brk_q;
  assign rx_flush   = rx_fl_q;
  assign tx_flush   = tx_fl_q;

  assert_rx_off_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[1]) |=> !rx_enable);

  assert_tx_off_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[3]) |=> !tx_enable);

  assert_brk_only_by_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(brk_active));
endmodule

// File: rtl/sio_chan_stat.sv
module sio_chan_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_evt,
  input  logic       par_evt,
  input  logic       frm_evt,
  input  logic       brk_evt,
  input  logic       err_clr,
  input  logic       brk_clr,
  output logic [3:0] flags
);
  logic ovr_q, ovr_d, par_q, par_d, frm_q, frm_d, brk_q, brk_d;

  always_comb begin
    ovr_d = ovr_evt || (ovr_q && !err_clr);
    par_d = par_evt || (par_q && !err_clr);
    frm_d = frm_evt || (frm_q && !err_clr);
    brk_d = brk_evt || (brk_q && !brk_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      par_q <= 1'b0;
      frm_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      par_q <= par_d;
      frm_q <= frm_d;
      brk_q <= brk_d;
    end
  end

  assign flags = {brk_q, frm_q, par_q, ovr_q};

  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !ovr_evt && !par_evt && !frm_evt) |=> (flags[2:0] == 3'b000));

  assert_err_clr_keeps_brk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !brk_clr && !brk_evt) |=> $stable(flags[3]));
endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
  import sio_chan_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              rx_enable,
  output logic              tx_enable,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic              brk_active,
  output logic [1:0]        fmt_data_bits,
  output logic [2:0]        fmt_parity,
  output logic [3:0]        fmt_stop_len,
  output logic              fifo_deep,
  output logic              tx_lvl_half,
  output logic [2:0]        baud_table,
  output logic [7:0]        clk_select,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  input  logic [7:0]        rx_byte,
  input  logic              rx_ready_in,
  input  logic              rx_full_in,
  input  logic              tx_ready_in,
  input  logic              tx_empty_in,
  input  logic              ovr_evt,
  input  logic              par_evt,
  input  logic              frm_evt,
  input  logic              brk_evt
);
  localparam int TAG_W = ADDR_W - WIN_W;

  acc_t       acc;
  logic [7:0] mode_val;
  logic       err_clr, brk_clr, aim_mr0, aim_mr1;
  logic [3:0] flags;
  logic [7:0] csel_q, txb_q;
  logic       push_q, pop_q;

  sio_chan_dec #(.ADDR_W(ADDR_W), .CHAN_IDX(CHAN_IDX)) u_dec (
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .acc(acc)
  );

  sio_chan_mode u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(acc.mode_wr), .mode_rd(acc.mode_rd),
    .wdata(bus_wdata), .aim_mr0(aim_mr0), .aim_mr1(aim_mr1), .rd_val(mode_val),
    .fmt_data_bits(fmt_data_bits), .fmt_parity(fmt_parity),
    .fmt_stop_len(fmt_stop_len), .fifo_deep(fifo_deep),
    .tx_lvl_half(tx_lvl_half), .baud_table(baud_table)
  );

  sio_chan_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(acc.cmd_wr), .wdata(bus_wdata),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .rx_flush(rx_flush),
    .tx_flush(tx_flush), .brk_active(brk_active), .err_clr(err_clr),
    .brk_clr(brk_clr), .aim_mr0(aim_mr0), .aim_mr1(aim_mr1)
  );

  sio_chan_stat u_stat (
    .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .par_evt(par_evt),
    .frm_evt(frm_evt), .brk_evt(brk_evt), .err_clr(err_clr),
    .brk_clr(brk_clr), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q <= '0;
    end else if (acc.csel_wr) begin
      csel_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q <= '0;
    end else if (acc.hold_wr) begin
      txb_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q <= 1'b0;
      pop_q  <= 1'b0;
    end else begin
      push_q <= acc.hold_wr;
      pop_q  <= acc.hold_rd;
    end
  end

  always_comb begin
    if (acc.mode_rd)      bus_rdata = mode_val;
    else if (acc.stat_rd) bus_rdata = {flags, tx_empty_in, tx_ready_in, rx_full_in, rx_ready_in};
    else if (acc.hold_rd) bus_rdata = rx_byte;
    else                  bus_rdata = '0;
  end

  assign clk_select = csel_q;
  assign tx_byte    = txb_q;
  assign tx_push    = push_q;
  assign rx_pop     = pop_q;

  assert_offwin_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_addr[ADDR_W-1:WIN_W] != TAG_W'(CHAN_IDX)) |=> (!tx_push && !rx_pop && $stable(clk_select)));

  assert_hold_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we && bus_addr == {TAG_W'(CHAN_IDX), OFS_HOLD}) |=> (tx_push && tx_byte == $past(bus_wdata)));
endmodule

// File: tb/test_sio_chan_regs.sv
`timescale 1ns/1ps
module test_sio_chan_regs;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_cs, bus_we, bus_re;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic rx_enable, tx_enable, rx_flush, tx_flush, brk_active;
  logic [1:0] fmt_data_bits;
  logic [2:0] fmt_parity, baud_table;
  logic [3:0] fmt_stop_len;
  logic fifo_deep, tx_lvl_half, tx_push, rx_pop;
  logic [7:0] clk_select, tx_byte, rx_byte;
  logic rx_ready_in, rx_full_in, tx_ready_in, tx_empty_in;
  logic ovr_evt, par_evt, frm_evt, brk_evt;

  int n_tot = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sio_chan_regs #(.ADDR_W(4), .CHAN_IDX(0)) i_sio_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .rx_flush(rx_flush),
    .tx_flush(tx_flush), .brk_active(brk_active), .fmt_data_bits(fmt_data_bits),
    .fmt_parity(fmt_parity), .fmt_stop_len(fmt_stop_len), .fifo_deep(fifo_deep),
    .tx_lvl_half(tx_lvl_half), .baud_table(baud_table), .clk_select(clk_select),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
    .rx_ready_in(rx_ready_in), .rx_full_in(rx_full_in), .tx_ready_in(tx_ready_in),
    .tx_empty_in(tx_empty_in), .ovr_evt(ovr_evt), .par_evt(par_evt),
    .frm_evt(frm_evt), .brk_evt(brk_evt)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_cs = 1'b0; bus_re = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R2 rx_enable", {7'd0, rx_enable}, 8'h00);
    chk("R2 tx_enable", {7'd0, tx_enable}, 8'h00);
    chk("R2 brk_active", {7'd0, brk_active}, 8'h00);
    chk("R2 mode fields", {fmt_parity, fmt_data_bits, baud_table}, 8'h00);
    chk("R2 flags", {fifo_deep, tx_lvl_half, fmt_stop_len}, 8'h00);
    chk("R2 clk_select", clk_select, 8'h00);
    rd(4'h1, v);
    chk("R2 status", v, 8'h00);
  endtask

  task automatic t_mode_seq;
    wr(4'h0, 8'h13);
    chk("R4 data bits via MR1", {6'd0, fmt_data_bits}, 8'h03);
    chk("R4 parity none", {5'd0, fmt_parity}, 8'h04);
    wr(4'h0, 8'h0F);
    chk("R5 two stop", {4'd0, fmt_stop_len}, 8'h0F);
    wr(4'h0, 8'h07);
    chk("R5 one stop", {4'd0, fmt_stop_len}, 8'h07);
    chk("R3 pointer held at MR2", {6'd0, fmt_data_bits}, 8'h03);
    wr(4'h2, 8'h10);
    wr(4'h0, 8'h06);
    chk("R3 code 1 aims MR1", {6'd0, fmt_data_bits}, 8'h02);
    chk("R4 parity odd", {5'd0, fmt_parity}, 8'h01);
    chk("R3 MR2 untouched", {4'd0, fmt_stop_len}, 8'h07);
  endtask

  task automatic t_mr0;
    wr(4'h2, 8'hB0);
    wr(4'h0, 8'h1D);
    chk("R6 baud ext2", {5'd0, baud_table}, 8'h05);
    chk("R6 fifo/half", {6'd0, fifo_deep, tx_lvl_half}, 8'h03);
    wr(4'h0, 8'h00);
    chk("R3 MR0 then MR1", {fmt_parity, fmt_data_bits}, 8'h00);
    chk("R6 MR0 kept", {5'd0, baud_table}, 8'h05);
    wr(4'h0, 8'h0F);
    chk("R3 then MR2", {4'd0, fmt_stop_len}, 8'h0F);
  endtask

  task automatic t_mode_read;
    logic [7:0] v;
    wr(4'h2, 8'hB0);
    rd(4'h0, v); chk("R3 read MR0", v, 8'h1D);
    rd(4'h0, v); chk("R3 read MR1", v, 8'h00);
    rd(4'h0, v); chk("R3 read MR2", v, 8'h0F);
    rd(4'h0, v); chk("R3 read stays MR2", v, 8'h0F);
  endtask

  task automatic t_cmd_en;
    wr(4'h2, 8'h05);
    chk("R7 both on", {6'd0, rx_enable, tx_enable}, 8'h03);
    wr(4'h2, 8'h02);
    chk("R7 rx off", {6'd0, rx_enable, tx_enable}, 8'h01);
    wr(4'h2, 8'h01);
    wr(4'h2, 8'h03);
    chk("R7 rx disable wins", {6'd0, rx_enable, tx_enable}, 8'h01);
    wr(4'h2, 8'h0C);
    chk("R7 tx disable wins", {6'd0, rx_enable, tx_enable}, 8'h00);
    wr(4'h2, 8'h15);
    chk("R7 bits with code", {6'd0, rx_enable, tx_enable}, 8'h03);
    wr(4'h0, 8'h01);
    chk("R7 code also applied", {6'd0, fmt_data_bits}, 8'h01);
  endtask

  task automatic t_strobes;
    wr(4'h2, 8'h20);
    chk("R8 rx_flush pulse", {6'd0, rx_flush, tx_flush}, 8'h02);
    @(negedge clk);
    chk("R8 rx_flush one cycle", {6'd0, rx_flush, tx_flush}, 8'h00);
    wr(4'h2, 8'h30);
    chk("R8 tx_flush pulse", {6'd0, rx_flush, tx_flush}, 8'h01);
    @(negedge clk);
    chk("R8 tx_flush one cycle", {6'd0, rx_flush, tx_flush}, 8'h00);
  endtask

  task automatic t_break;
    wr(4'h2, 8'h60);
    chk("R9 break on", {7'd0, brk_active}, 8'h01);
    wr(4'h2, 8'h90);
    chk("R9 other code keeps break", {7'd0, brk_active}, 8'h01);
    wr(4'h2, 8'h70);
    chk("R9 break off", {7'd0, brk_active}, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    @(negedge clk);
    rx_ready_in = 1'b1; tx_empty_in = 1'b1;
    rd(4'h1, v); chk("R10 live bits", v, 8'h09);
    @(negedge clk);
    ovr_evt = 1'b1; par_evt = 1'b1; frm_evt = 1'b1; brk_evt = 1'b1;
    @(negedge clk);
    ovr_evt = 1'b0; par_evt = 1'b0; frm_evt = 1'b0; brk_evt = 1'b0;
    rd(4'h1, v); chk("R10 sticky bits", v, 8'hF9);
    wr(4'h2, 8'h40);
    rd(4'h1, v); chk("R11 error clear keeps break", v, 8'h89);
    wr(4'h2, 8'h50);
    rd(4'h1, v); chk("R11 break clear", v, 8'h09);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 4'h2; bus_wdata = 8'h40; ovr_evt = 1'b1;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0; ovr_evt = 1'b0;
    rd(4'h1, v); chk("R11 event beats clear", v, 8'h19);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    wr(4'h3, 8'hA5);
    chk("R12 tx_push", {7'd0, tx_push}, 8'h01);
    chk("R12 tx_byte", tx_byte, 8'hA5);
    @(negedge clk);
    chk("R12 tx_push one cycle", {7'd0, tx_push}, 8'h00);
    rx_byte = 8'h3C;
    rd(4'h3, v);
    chk("R12 rx byte read", v, 8'h3C);
    chk("R12 rx_pop", {7'd0, rx_pop}, 8'h01);
  endtask

  task automatic t_csel;
    wr(4'h1, 8'h66);
    chk("R13 clk_select", clk_select, 8'h66);
  endtask

  task automatic t_decode;
    logic [7:0] v;
    wr(4'hA, 8'h0A);
    chk("R1 foreign cmd ignored", {6'd0, rx_enable, tx_enable}, 8'h03);
    wr(4'h9, 8'h11);
    chk("R1 foreign csel ignored", clk_select, 8'h66);
    rd(4'hB, v);
    chk("R1 foreign read zero", v, 8'h00);
    chk("R1 foreign read no pop", {7'd0, rx_pop}, 8'h00);
    wr(4'hB, 8'h77);
    chk("R1 foreign hold no push", {7'd0, tx_push}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_cs = 0; bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
    rx_byte = '0; rx_ready_in = 0; rx_full_in = 0; tx_ready_in = 0; tx_empty_in = 0;
    ovr_evt = 0; par_evt = 0; frm_evt = 0; brk_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_seq();
    t_mr0();
    t_mode_read();
    t_cmd_en();
    t_strobes();
    t_break();
    t_status();
    t_hold();
    t_csel();
    t_decode();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_tot++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end
endmodule